// File: doc/BRIEF.md
# Fixed-Burst AHB Command Splitter

This block takes a block-transfer request from a DMA engine and turns it into a series of AHB-Lite burst commands for the master port. A request gives a word-aligned start address and a total number of 32-bit beats. The engine's programmed beat limit splits the transfer into DMA transactions. Each transaction holds at most that many beats. The block then covers each transaction with the fewest fixed bursts it can, using INCR16, INCR8, INCR4 and SINGLE. A limit larger than 16 is served with several INCR16 bursts, because no single AHB burst is longer than 16 beats.

Receive and transmit can use different limits. Every limit is checked against the legal set and against half the FIFO depth before any command goes out. An optional alignment mode issues shorter bursts first until the address is aligned to the burst size. No burst ever crosses a 1 KB address boundary.

Commands leave one at a time on a valid/ready handshake. A one-cycle done pulse marks the end of the transfer.

Top module: `bsplit_top`

## Requirements
- R1: The effective limit is legal only if it is one of 1, 2, 4, 8, 16 or 32 and does not exceed FIFO_DEPTH/2. For an illegal limit, `cfg_err` pulses high for exactly one cycle after the request is taken, and no command is issued.
- R2: When `cfg_rx_sep` is 1 and `req_rx` is 1, the effective limit is `cfg_rx_pbl`. In every other case it is `cfg_pbl`, and `cfg_rx_pbl` has no effect.
- R3: The transfer is cut into transactions of min(limit, beats left) beats. No burst spans two transactions, so a limit of 32 is served as INCR16 followed by INCR16.
- R4: In fixed mode (`cfg_aligned`=0), each command is the largest of INCR16, INCR8 and INCR4 that fits both the beats left in the transaction and the words left before the next 1 KB boundary. If none fits, the command is a SINGLE. The `cmd_burst` encoding is SINGLE=3'b000, INCR4=3'b011, INCR8=3'b101, INCR16=3'b111, and `cmd_beats` gives 1, 4, 8 or 16 to match.
- R5: No command covers addresses on both sides of a 1 KB boundary.
- R6: In aligned mode (`cfg_aligned`=1), a burst of N beats is used only when the word address is a multiple of N. Otherwise a smaller burst or SINGLE is used, and alignment is never pursued beyond 16 beats.
- R7: While `cmd_valid` is high and `cmd_ready` is low, `cmd_addr`, `cmd_burst` and `cmd_beats` hold their values.
- R8: After each accepted command, the next command's address is the previous address plus 4 bytes times `cmd_beats`. Address bits [1:0] of the request are forced to zero.
- R9: `done` pulses for one cycle, in the cycle after the last command is accepted. A request of zero beats with a legal limit produces only the `done` pulse, one cycle after it is taken.
- R10: A 16-byte descriptor fetch (a 4-beat request at a 16-byte-aligned address) is issued as one INCR4 when the limit is 4 or more, and as four SINGLEs when the limit is 1 or 2.
- R11: `req_ready` is high exactly when no transfer is in progress, and `cmd_valid` is high exactly when one is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Transfer request present |
| req_ready | output | 1 | Block idle, request taken |
| req_addr | input | 32 | Start byte address (word aligned) |
| req_beats | input | CNT_W | Total 32-bit beats |
| req_rx | input | 1 | 1 = receive direction |
| cfg_pbl | input | 6 | Main beat limit |
| cfg_rx_pbl | input | 6 | Receive-only beat limit |
| cfg_rx_sep | input | 1 | Use separate receive limit |
| cfg_aligned | input | 1 | Address-aligned burst mode |
| cmd_valid | output | 1 | Burst command present |
| cmd_ready | input | 1 | Burst command accepted |
| cmd_addr | output | 32 | Burst start byte address |
| cmd_burst | output | 3 | HBURST code |
| cmd_beats | output | 5 | Beats in this burst |
| done | output | 1 | One-cycle transfer completion |
| cfg_err | output | 1 | One-cycle illegal-limit flag |

## Verification
The assertions check, on every cycle, the properties that each command must have on its own:
- the burst code and the beat count agree;
- no command crosses a 1 KB boundary;
- in aligned mode, the address is aligned to the burst size;
- a stalled command holds its values;
- `done` lasts one cycle, and neither `done` nor the error flag coincides with a live command.

Only the bench scenarios can show that the sequence of bursts is the best one. This covers how transactions are chunked under each limit, how the receive-limit selection works, the address stepping and the descriptor case. It also covers the rejection of limits that are illegal or larger than the FIFO allows.

// File: rtl/bsplit_pkg.sv
package bsplit_pkg;

    localparam int ADDR_W   = 32;
    localparam int LIM_W    = 6;
    localparam int BEAT_W   = 5;
    localparam int KB_WORDS = 256;

    typedef enum logic [2:0] {
        HB_SINGLE = 3'b000,
        HB_INCR4  = 3'b011,
        HB_INCR8  = 3'b101,
        HB_INCR16 = 3'b111
    } hburst_e;

    // power of two, nonzero, and within the FIFO half-depth cap
    function automatic logic lim_legal(logic [LIM_W-1:0] v, int cap);
        return (v != '0) && ((v & (v - 1'b1)) == '0) && (int'(v) <= cap);
    endfunction

endpackage

// File: rtl/bsplit_limit_sel.sv
module bsplit_limit_sel
    import bsplit_pkg::*;
#(
    parameter int FIFO_DEPTH = 64
) (
    input  logic             dir_rx,
    input  logic             rx_sep,
    input  logic [LIM_W-1:0] pbl,
    input  logic [LIM_W-1:0] rx_pbl,
    output logic [LIM_W-1:0] lim,
    output logic             legal
);
    localparam int CAP = FIFO_DEPTH / 2;

    always_comb begin
        lim   = (dir_rx && rx_sep) ? rx_pbl : pbl;
        legal = lim_legal(lim, CAP);
    end
endmodule

// File: rtl/bsplit_burst_pick.sv
module bsplit_burst_pick
    import bsplit_pkg::*;
(
    input  logic [7:0]        word_lo,
    input  logic [LIM_W-1:0]  chunk_left,
    input  logic              aligned,
    output hburst_e           burst,
    output logic [BEAT_W-1:0] beats
);
    int to_bnd;

    always_comb begin
        to_bnd = KB_WORDS - int'(word_lo);
        burst  = HB_SINGLE;
        beats  = BEAT_W'(1);
        // ascending sizes: the largest that fits wins
        for (int i = 0; i < 3; i++) begin
            if (int'(chunk_left) >= (4 << i) && to_bnd >= (4 << i) &&
                (!aligned || ((int'(word_lo) & ((4 << i) - 1)) == 0))) begin
                beats = BEAT_W'(4 << i);
                case (i)
                    0:       burst = HB_INCR4;
                    1:       burst = HB_INCR8;
                    default: burst = HB_INCR16;
                endcase
            end
        end
    end
endmodule

// File: rtl/bsplit_top.sv
module bsplit_top
    import bsplit_pkg::*;
#(
    parameter int FIFO_DEPTH = 64,
    parameter int CNT_W      = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [31:0]       req_addr,
    input  logic [CNT_W-1:0]  req_beats,
    input  logic              req_rx,
    input  logic [5:0]        cfg_pbl,
    input  logic [5:0]        cfg_rx_pbl,
    input  logic              cfg_rx_sep,
    input  logic              cfg_aligned,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [31:0]       cmd_addr,
    output logic [2:0]        cmd_burst,
    output logic [4:0]        cmd_beats,
    output logic              done,
    output logic              cfg_err
);
    logic               busy, algn, done_q, err_q;
    logic [ADDR_W-1:0]  cur_addr;
    logic [CNT_W-1:0]   rem;
    logic [LIM_W-1:0]   chunk, lim;

    logic [LIM_W-1:0]   sel_lim;
    logic               sel_legal;
    hburst_e            pick_burst;
    logic [BEAT_W-1:0]  pick_beats;

    logic [CNT_W-1:0]   rem_next, req_lim_ext, cur_lim_ext;
    logic [LIM_W-1:0]   first_chunk, next_chunk;

    bsplit_limit_sel #(.FIFO_DEPTH(FIFO_DEPTH)) u_lim (
        .dir_rx (req_rx),
        .rx_sep (cfg_rx_sep),
        .pbl    (cfg_pbl),
        .rx_pbl (cfg_rx_pbl),
        .lim    (sel_lim),
        .legal  (sel_legal)
    );

    bsplit_burst_pick u_pick (
        .word_lo    (cur_addr[9:2]),
        .chunk_left (chunk),
        .aligned    (algn),
        .burst      (pick_burst),
        .beats      (pick_beats)
    );

    always_comb begin
        req_lim_ext = CNT_W'(sel_lim);
        cur_lim_ext = CNT_W'(lim);
        rem_next    = rem - CNT_W'(pick_beats);
        first_chunk = (req_beats < req_lim_ext) ? LIM_W'(req_beats) : sel_lim;
        next_chunk  = (rem_next < cur_lim_ext) ? LIM_W'(rem_next) : lim;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            algn     <= 1'b0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
            cur_addr <= '0;
            rem      <= '0;
            chunk    <= '0;
            lim      <= '0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            if (!busy) begin
                if (req_valid) begin
                    if (!sel_legal) begin
                        err_q <= 1'b1;
                    end else if (req_beats == '0) begin
                        done_q <= 1'b1;
                    end else begin
                        busy     <= 1'b1;
                        cur_addr <= req_addr & ~ADDR_W'(3);
                        rem      <= req_beats;
                        lim      <= sel_lim;
                        chunk    <= first_chunk;
                        algn     <= cfg_aligned;
                    end
                end
            end else if (cmd_ready) begin
                cur_addr <= cur_addr + (ADDR_W'(pick_beats) << 2);
                rem      <= rem_next;
                if (rem_next == '0) begin
                    busy   <= 1'b0;
                    done_q <= 1'b1;
                end else if (chunk == LIM_W'(pick_beats)) begin
                    chunk <= next_chunk;
                end else begin
                    chunk <= chunk - LIM_W'(pick_beats);
                end
            end
        end
    end

    assign req_ready = !busy;
    assign cmd_valid = busy;
    assign cmd_addr  = cur_addr;
    assign cmd_burst = pick_burst;
    assign cmd_beats = pick_beats;
    assign done      = done_q;
    assign cfg_err   = err_q;

    // ---------------- assertions ----------------
    assert_burst_code_R4: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> ((cmd_burst == 3'b000 && cmd_beats == 5'd1)  ||
                       (cmd_burst == 3'b011 && cmd_beats == 5'd4)  ||
                       (cmd_burst == 3'b101 && cmd_beats == 5'd8)  ||
                       (cmd_burst == 3'b111 && cmd_beats == 5'd16)));

    assert_no_kb_cross_R5: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> ({1'b0, cmd_addr[9:2]} + 9'(cmd_beats)) <= 9'd256);

    assert_aligned_R6: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && algn) |-> ((cmd_addr[5:2] & 4'(cmd_beats - 5'd1)) == 4'd0));

    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr) &&
                                       $stable(cmd_burst) && $stable(cmd_beats)));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> !cmd_valid);

    assert_err_idle_R1: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> (!cmd_valid && !done));

    assert_handshake_R11: assert property (@(posedge clk) disable iff (rst)
        req_ready != cmd_valid);
endmodule

// File: tb/bsplit_top_tb_top.sv
module bsplit_top_tb_top;
    localparam int CNT_W = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [CNT_W-1:0] req_beats = '0;
    logic req_rx = 1'b0;
    logic [5:0] cfg_pbl = 6'd16;
    logic [5:0] cfg_rx_pbl = 6'd16;
    logic cfg_rx_sep = 1'b0;
    logic cfg_aligned = 1'b0;
    logic cmd_ready = 1'b1;

    logic req_ready, cmd_valid, done, cfg_err;
    logic [31:0] cmd_addr;
    logic [2:0] cmd_burst;
    logic [4:0] cmd_beats;

    logic s_req_ready, s_cmd_valid, s_done, s_err;
    logic [31:0] s_cmd_addr;
    logic [2:0] s_cmd_burst;
    logic [4:0] s_cmd_beats;

    int n_tests = 0;
    int n_fail  = 0;

    logic [31:0] ex_addr  [0:15];
    logic [2:0]  ex_burst [0:15];
    logic [4:0]  ex_beats [0:15];
    int ex_n;

    always #10 clk = ~clk;

    bsplit_top #(.FIFO_DEPTH(64), .CNT_W(CNT_W)) dut_i (
        .clk, .rst, .req_valid, .req_ready, .req_addr, .req_beats, .req_rx,
        .cfg_pbl, .cfg_rx_pbl, .cfg_rx_sep, .cfg_aligned,
        .cmd_valid, .cmd_ready, .cmd_addr, .cmd_burst, .cmd_beats,
        .done, .cfg_err
    );

    bsplit_top #(.FIFO_DEPTH(16), .CNT_W(CNT_W)) dut_small_i (
        .clk, .rst, .req_valid, .req_ready(s_req_ready), .req_addr, .req_beats, .req_rx,
        .cfg_pbl, .cfg_rx_pbl, .cfg_rx_sep, .cfg_aligned,
        .cmd_valid(s_cmd_valid), .cmd_ready, .cmd_addr(s_cmd_addr),
        .cmd_burst(s_cmd_burst), .cmd_beats(s_cmd_beats),
        .done(s_done), .cfg_err(s_err)
    );

    task automatic check_eq(string tag, string what, longint act, longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic ex_clear();
        ex_n = 0;
    endtask

    task automatic ex_add(logic [31:0] a, logic [2:0] b, logic [4:0] n);
        ex_addr[ex_n]  = a;
        ex_burst[ex_n] = b;
        ex_beats[ex_n] = n;
        ex_n++;
    endtask

    // issue a request; returns at the negedge after it was taken
    task automatic send(logic [31:0] a, int beats, logic rx);
        @(negedge clk);
        req_addr  = a;
        req_beats = CNT_W'(beats);
        req_rx    = rx;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // compare accepted commands with the expected list, then the done pulse
    task automatic collect(string tag);
        int k = 0;
        int guard = 0;
        while (!done && guard < 300) begin
            if (cmd_valid) begin
                if (k < ex_n) begin
                    check_eq(tag, "addr",  cmd_addr,  ex_addr[k]);
                    check_eq(tag, "burst", cmd_burst, ex_burst[k]);
                    check_eq(tag, "beats", cmd_beats, ex_beats[k]);
                end
                k++;
            end
            @(negedge clk);
            guard++;
        end
        check_eq(tag, "command count", k, ex_n);
        check_eq(tag, "done seen", done, 1);
        @(negedge clk);
        check_eq({tag, " R9"}, "done one cycle", done, 0);
        check_eq({tag, " R11"}, "idle ready", req_ready, 1);
    endtask

    task automatic t_reset();
        check_eq("R11 reset", "req_ready", req_ready, 1);
        check_eq("R11 reset", "cmd_valid", cmd_valid, 0);
        check_eq("R9 reset", "done", done, 0);
        check_eq("R1 reset", "cfg_err", cfg_err, 0);
    endtask

    // R3: limit 32 as two INCR16, then the tail transaction
    task automatic t_limit32();
        cfg_pbl = 6'd32; cfg_aligned = 1'b0; cfg_rx_sep = 1'b0;
        ex_clear();
        ex_add(32'h1000, 3'b111, 5'd16);
        ex_add(32'h1040, 3'b111, 5'd16);
        ex_add(32'h1080, 3'b101, 5'd8);
        send(32'h1000, 40, 1'b0);
        collect("R3 limit32");
    endtask

    // R7: stall the first command, values must hold
    task automatic t_stall();
        cfg_pbl = 6'd16; cfg_aligned = 1'b0;
        cmd_ready = 1'b0;
        send(32'h1800, 16, 1'b0);
        for (int i = 0; i < 3; i++) begin
            check_eq("R7 stall", "valid", cmd_valid, 1);
            check_eq("R7 stall", "addr", cmd_addr, 32'h1800);
            check_eq("R7 stall", "burst", cmd_burst, 3'b111);
            @(negedge clk);
        end
        cmd_ready = 1'b1;
        ex_clear();
        ex_add(32'h1800, 3'b111, 5'd16);
        collect("R7 stall");
    endtask

    // R4 R8: fixed mode on an unaligned start
    task automatic t_fixed_unaligned();
        cfg_pbl = 6'd16; cfg_aligned = 1'b0;
        ex_clear();
        ex_add(32'h2004, 3'b011, 5'd4);
        ex_add(32'h2014, 3'b000, 5'd1);
        ex_add(32'h2018, 3'b000, 5'd1);
        ex_add(32'h201C, 3'b000, 5'd1);
        send(32'h2006, 7, 1'b0);
        collect("R4 R8 fixed");
    endtask

    // R6: address-aligned mode
    task automatic t_aligned();
        cfg_pbl = 6'd16; cfg_aligned = 1'b1;
        ex_clear();
        ex_add(32'h3004, 3'b000, 5'd1);
        ex_add(32'h3008, 3'b000, 5'd1);
        ex_add(32'h300C, 3'b000, 5'd1);
        ex_add(32'h3010, 3'b011, 5'd4);
        ex_add(32'h3020, 3'b101, 5'd8);
        ex_add(32'h3040, 3'b000, 5'd1);
        ex_add(32'h3044, 3'b000, 5'd1);
        ex_add(32'h3048, 3'b000, 5'd1);
        ex_add(32'h304C, 3'b000, 5'd1);
        ex_add(32'h3050, 3'b000, 5'd1);
        send(32'h3004, 20, 1'b0);
        collect("R6 aligned");
        cfg_aligned = 1'b0;
    endtask

    // R5: 1 KB boundary
    task automatic t_boundary();
        cfg_pbl = 6'd16;
        ex_clear();
        ex_add(32'h03F0, 3'b011, 5'd4);
        ex_add(32'h0400, 3'b101, 5'd8);
        ex_add(32'h0420, 3'b011, 5'd4);
        send(32'h03F0, 16, 1'b0);
        collect("R5 boundary");
    endtask

    // R1: illegal values and FIFO half-depth rule
    task automatic t_illegal();
        cfg_pbl = 6'd12;
        send(32'h4000, 8, 1'b0);
        check_eq("R1 pbl12", "cfg_err", cfg_err, 1);
        check_eq("R1 pbl12", "cmd_valid", cmd_valid, 0);
        @(negedge clk);
        check_eq("R1 pbl12", "err one cycle", cfg_err, 0);
        check_eq("R1 pbl12", "cmd_valid after", cmd_valid, 0);
        cfg_pbl = 6'd0;
        send(32'h4000, 8, 1'b0);
        check_eq("R1 pbl0", "cfg_err", cfg_err, 1);
        @(negedge clk);
        cfg_pbl = 6'd16;
        send(32'h4000, 0, 1'b0);
        check_eq("R1 fifo cap", "small err", s_err, 1);
        check_eq("R1 fifo cap", "big err", cfg_err, 0);
        check_eq("R9 zero beats", "done", done, 1);
        check_eq("R9 zero beats", "cmd_valid", cmd_valid, 0);
        @(negedge clk);
        cfg_pbl = 6'd8;
        send(32'h4000, 0, 1'b0);
        check_eq("R1 fifo ok", "small err", s_err, 0);
        check_eq("R1 fifo ok", "small done", s_done, 1);
        @(negedge clk);
    endtask

    // R2: receive-limit selection
    task automatic t_rx_sel();
        cfg_pbl = 6'd16; cfg_rx_pbl = 6'd4; cfg_rx_sep = 1'b1;
        ex_clear();
        ex_add(32'h5000, 3'b011, 5'd4);
        ex_add(32'h5010, 3'b011, 5'd4);
        send(32'h5000, 8, 1'b1);
        collect("R2 rx sep");
        ex_clear();
        ex_add(32'h5000, 3'b101, 5'd8);
        send(32'h5000, 8, 1'b0);
        collect("R2 tx sep");
        cfg_rx_sep = 1'b0; cfg_rx_pbl = 6'd3;
        ex_clear();
        ex_add(32'h5000, 3'b101, 5'd8);
        send(32'h5000, 8, 1'b1);
        check_eq("R2 shared", "no err", cfg_err, 0);
        collect("R2 shared");
    endtask

    // R10: descriptor fetch
    task automatic t_desc();
        cfg_pbl = 6'd32;
        ex_clear();
        ex_add(32'h6000, 3'b011, 5'd4);
        send(32'h6000, 4, 1'b0);
        collect("R10 desc pbl32");
        foreach (ex_addr[i]) ex_addr[i] = '0;
        cfg_pbl = 6'd1;
        ex_clear();
        for (int i = 0; i < 4; i++) ex_add(32'h6000 + 32'(4 * i), 3'b000, 5'd1);
        send(32'h6000, 4, 1'b0);
        collect("R10 desc pbl1");
        cfg_pbl = 6'd2;
        send(32'h6000, 4, 1'b0);
        collect("R10 desc pbl2");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_limit32();
        t_stall();
        t_fixed_unaligned();
        t_aligned();
        t_boundary();
        t_illegal();
        t_rx_sel();
        t_desc();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule